// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide parallel NOR flash. It watches synchronous bus write cycles, each an address and a data byte qualified by a one-cycle write strobe. It recognises the protected multi-cycle instruction sequences and turns each finished instruction into a one-cycle start pulse for a program/erase controller. The array itself and the real program and erase timing lie outside it. The controller reports its state through a `busy_i` level and a `done_i` pulse.

Every instruction starts with two coded unlock writes, then a command byte. Program takes one more write that carries the target address and data. Erase takes a setup byte, a second unlock pair, and a confirm byte. The confirm byte picks either one 64 KB block, addressed by the top three address bits, or the whole chip. Any write that breaks the expected order drops the decoder back to its first step and to array read mode. While the controller is busy, only an erase-suspend byte has any effect. A suspended erase is resumed by a single confirm-byte write. The block also tracks which read view the host should see: array, signature, or status.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, or after a reset applied partway through a sequence, all pulses are low, `read_mode_o` is 0 (array), and a sequence must restart from its first unlock write.
- R2: The unlock pair is data AAh at address 5555h, then data 55h at address 2AAAh. Only the low 15 address bits are compared, so address bits 18:15 are don't-care.
- R3: The sequence unlock pair, A0h, then one more write produces `pgm_start_o` for one cycle, with `pgm_addr_o`/`pgm_data_o` equal to that write's address and data. The final write accepts any byte, F0h included. `read_mode_o` becomes 2 (status) in the same cycle.
- R4: The sequence unlock pair, 80h, unlock pair, 30h produces `blk_erase_o`, with `blk_sel_o` equal to address bits 18:16 of the 30h write. `read_mode_o` becomes 2.
- R5: The sequence unlock pair, 80h, unlock pair, 10h produces `chip_erase_o`, and `read_mode_o` becomes 2.
- R6: The sequence unlock pair, 90h produces `sig_read_o`, and `read_mode_o` becomes 1 (signature).
- R7: A write that does not match the expected step (a wrong unlock address or byte, or an unknown command or confirm byte) produces no pulse, sets `read_mode_o` to 0, and returns the decoder to its first step.
- R8: An F0h write at any step other than the program data write produces no pulse and returns the decoder to array mode.
- R9: While `busy_i` is high, writes produce no start pulse and leave `read_mode_o` unchanged.
- R10: A B0h write while `busy_i` is high and an erase is running produces `suspend_o`, and `read_mode_o` becomes 0. During a program operation, B0h is ignored.
- R11: A 30h write at the first step, while an erase is suspended and `busy_i` is low, produces `resume_o` and sets `read_mode_o` to 2.
- R12: A `done_i` pulse sets `read_mode_o` to 0 on the next edge and ends the running erase. It takes priority over any other mode change in that cycle.
- R13: Every pulse output is high for exactly one cycle, in the cycle after the write that completes it. At most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one cycle per bus write |
| addr_i | input | 19 | Write address |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | Controller is running an operation |
| done_i | input | 1 | Controller finished its operation (pulse) |
| pgm_start_o | output | 1 | Program start pulse |
| pgm_addr_o | output | 19 | Program target address |
| pgm_data_o | output | 8 | Program data byte |
| blk_erase_o | output | 1 | Block erase start pulse |
| blk_sel_o | output | 3 | Block to erase |
| chip_erase_o | output | 1 | Chip erase start pulse |
| suspend_o | output | 1 | Erase suspend pulse |
| resume_o | output | 1 | Erase resume pulse |
| sig_read_o | output | 1 | Signature read entry pulse |
| read_mode_o | output | 2 | Read view: 0 array, 1 signature, 2 status |

## Verification
The bench targets the steps where a decoder most often slips. One case breaks the second unlock by a single address bit; a decoder that checks only the data byte would accept it and start a program. Another unlocks with high address bits set; comparing the full address would reject that valid sequence. Other cases write B0h during a program, where a wrong decoder would emit a suspend it cannot honour, and F0h as program data, where a wrong decoder would swallow the program as a reset. A final case applies reset between the unlocks and the command byte; a state machine that survives reset would then start a program.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_CMD, S_PGM, S_EU0, S_EU1, S_ECF
  } seq_e;

  typedef enum logic [1:0] {
    M_ARRAY = 2'd0,
    M_SIG   = 2'd1,
    M_STAT  = 2'd2
  } rmode_e;

  localparam logic [7:0] C_CHIP  = 8'h10;
  localparam logic [7:0] C_BLK   = 8'h30;
  localparam logic [7:0] C_SETUP = 8'h80;
  localparam logic [7:0] C_SIG   = 8'h90;
  localparam logic [7:0] C_PGM   = 8'hA0;
  localparam logic [7:0] C_SUSP  = 8'hB0;
  localparam logic [7:0] C_UNL_A = 8'hAA;
  localparam logic [7:0] C_UNL_B = 8'h55;

  localparam logic [14:0] A_UNL_A = 15'h5555;
  localparam logic [14:0] A_UNL_B = 15'h2AAA;

endpackage

// File: rtl/fcd_unlock_chk.sv
module fcd_unlock_chk
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W = 15
) (
  input  logic [CMP_W-1:0] addr_i,
  input  logic [7:0]       data_i,
  output logic [1:0]       hit_o
);
  localparam logic [CMP_W-1:0] KEY_A [2] = '{CMP_W'(A_UNL_A), CMP_W'(A_UNL_B)};
  localparam logic [7:0]       KEY_D [2] = '{C_UNL_A, C_UNL_B};

  for (genvar g = 0; g < 2; g++) begin : g_step
    assign hit_o[g] = (addr_i == KEY_A[g]) && (data_i == KEY_D[g]);
  end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [1:0]        hit_i,
  output logic              idle_o,
  output logic              ev_start_o,
  output logic              ev_erase_o,
  output logic              ev_sig_o,
  output logic              ev_abort_o,
  output logic              pgm_o,
  output logic              blk_o,
  output logic              chip_o,
  output logic              sig_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o,
  output logic [BLK_W-1:0]  blk_sel_o
);
  seq_e st_q, st_d;
  logic pgm_d, blk_d, chip_d, sig_d, abort_d;

  always_comb begin
    st_d    = st_q;
    pgm_d   = 1'b0;
    blk_d   = 1'b0;
    chip_d  = 1'b0;
    sig_d   = 1'b0;
    abort_d = 1'b0;
    if (wr_i) begin
      st_d = S_IDLE;
      unique case (st_q)
        S_IDLE: if (hit_i[0]) st_d = S_UNL1; else abort_d = 1'b1;
        S_UNL1: if (hit_i[1]) st_d = S_CMD;  else abort_d = 1'b1;
        S_CMD: begin
          if (data_i == C_PGM)        st_d  = S_PGM;
          else if (data_i == C_SETUP) st_d  = S_EU0;
          else if (data_i == C_SIG)   sig_d = 1'b1;
          else                        abort_d = 1'b1;
        end
        S_PGM:  pgm_d = 1'b1;  // any byte is program data
        S_EU0:  if (hit_i[0]) st_d = S_EU1; else abort_d = 1'b1;
        S_EU1:  if (hit_i[1]) st_d = S_ECF; else abort_d = 1'b1;
        S_ECF: begin
          if (data_i == C_CHIP)     chip_d  = 1'b1;
          else if (data_i == C_BLK) blk_d   = 1'b1;
          else                      abort_d = 1'b1;
        end
        default: abort_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      pgm_o  <= 1'b0;
      blk_o  <= 1'b0;
      chip_o <= 1'b0;
      sig_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pgm_o  <= pgm_d;
      blk_o  <= blk_d;
      chip_o <= chip_d;
      sig_o  <= sig_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_addr_o <= '0;
      tgt_data_o <= '0;
      blk_sel_o  <= '0;
    end else begin
      if (pgm_d) begin
        tgt_addr_o <= addr_i;
        tgt_data_o <= data_i;
      end
      if (blk_d) blk_sel_o <= addr_i[ADDR_W-1 -: BLK_W];
    end
  end

  assign idle_o     = (st_q == S_IDLE);
  assign ev_start_o = pgm_d | blk_d | chip_d;
  assign ev_erase_o = blk_d | chip_d;
  assign ev_sig_o   = sig_d;
  assign ev_abort_o = abort_d;

  a_r13_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pgm_o, blk_o, chip_o, sig_o}));
  a_r3_pgm_from_data_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_d |=> pgm_o && st_q == S_IDLE);
  a_r7_abort_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_d |=> st_q == S_IDLE && !(pgm_o || blk_o || chip_o || sig_o));
endmodule

// File: rtl/fcd_mode_trk.sv
module fcd_mode_trk
  import flash_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  input  logic       busy_i,
  input  logic       done_i,
  input  logic       idle_i,
  input  logic       ev_start_i,
  input  logic       ev_erase_i,
  input  logic       ev_sig_i,
  input  logic       ev_abort_i,
  output logic       susp_o,
  output logic       res_o,
  output rmode_e     mode_o
);
  logic   ers_q, held_q;
  logic   sus_d, res_d;
  rmode_e mode_d;

  assign sus_d = wr_i & busy_i & (data_i == C_SUSP) & ers_q & ~held_q;
  assign res_d = wr_i & ~busy_i & idle_i & (data_i == C_BLK) & held_q;

  always_comb begin
    mode_d = mode_o;
    if (ev_abort_i) mode_d = M_ARRAY;
    if (ev_sig_i)   mode_d = M_SIG;
    if (ev_start_i) mode_d = M_STAT;
    if (sus_d)      mode_d = M_ARRAY;
    if (res_d)      mode_d = M_STAT;   // beats the abort of an unexpected 30h
    if (done_i)     mode_d = M_ARRAY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= M_ARRAY;
      ers_q  <= 1'b0;
      held_q <= 1'b0;
      susp_o <= 1'b0;
      res_o  <= 1'b0;
    end else begin
      mode_o <= mode_d;
      susp_o <= sus_d;
      res_o  <= res_d;
      if (done_i)          ers_q <= 1'b0;
      else if (ev_erase_i) ers_q <= 1'b1;
      if (sus_d)      held_q <= 1'b1;
      else if (res_d) held_q <= 1'b0;
    end
  end

  a_r10_suspend_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> $past(busy_i) && mode_o == M_ARRAY);
  a_r11_resume_while_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_o |-> !$past(busy_i) && mode_o == M_STAT);
  a_r12_done_to_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> mode_o == M_ARRAY);
  a_r13_suspend_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |=> !susp_o);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3,
  parameter int CMP_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              pgm_start_o,
  output logic [ADDR_W-1:0] pgm_addr_o,
  output logic [7:0]        pgm_data_o,
  output logic              blk_erase_o,
  output logic [BLK_W-1:0]  blk_sel_o,
  output logic              chip_erase_o,
  output logic              suspend_o,
  output logic              resume_o,
  output logic              sig_read_o,
  output logic [1:0]        read_mode_o
);
  logic [1:0] hit;
  logic       wr_ok, idle, ev_start, ev_erase, ev_sig, ev_abort;
  rmode_e     mode;

  assign wr_ok = wr_i & ~busy_i;

  fcd_unlock_chk #(.CMP_W(CMP_W)) u_unl (
    .addr_i (addr_i[CMP_W-1:0]),
    .data_i (data_i),
    .hit_o  (hit)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_ok),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .hit_i      (hit),
    .idle_o     (idle),
    .ev_start_o (ev_start),
    .ev_erase_o (ev_erase),
    .ev_sig_o   (ev_sig),
    .ev_abort_o (ev_abort),
    .pgm_o      (pgm_start_o),
    .blk_o      (blk_erase_o),
    .chip_o     (chip_erase_o),
    .sig_o      (sig_read_o),
    .tgt_addr_o (pgm_addr_o),
    .tgt_data_o (pgm_data_o),
    .blk_sel_o  (blk_sel_o)
  );

  fcd_mode_trk u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .data_i     (data_i),
    .busy_i     (busy_i),
    .done_i     (done_i),
    .idle_i     (idle),
    .ev_start_i (ev_start),
    .ev_erase_i (ev_erase),
    .ev_sig_i   (ev_sig),
    .ev_abort_i (ev_abort),
    .susp_o     (suspend_o),
    .res_o      (resume_o),
    .mode_o     (mode)
  );

  assign read_mode_o = mode;

  a_r9_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(pgm_start_o || blk_erase_o || chip_erase_o || sig_read_o));
  a_r3_start_shows_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_start_o || blk_erase_o || chip_erase_o) |-> read_mode_o == 2'd2);
  a_r6_sig_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_read_o |-> read_mode_o == 2'd1);
  a_r13_pgm_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_start_o |=> !pgm_start_o);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, busy = 1'b0, done = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  data = '0;
  logic        pgm, blk, chip, sus, res, sig;
  logic [18:0] paddr;
  logic [7:0]  pdata;
  logic [2:0]  bsel;
  logic [1:0]  mode;
  int          n_run = 0, n_fail = 0;
  bit          fin = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .done_i(done), .pgm_start_o(pgm), .pgm_addr_o(paddr),
    .pgm_data_o(pdata), .blk_erase_o(blk), .blk_sel_o(bsel), .chip_erase_o(chip),
    .suspend_o(sus), .resume_o(res), .sig_read_o(sig), .read_mode_o(mode)
  );

  // {wr, busy, done, addr[18:0], data, exp_mode, exp {pgm,blk,chip,sus,res,sig}}
  localparam int NV = 42;
  localparam logic [37:0] VEC [NV] = '{
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},  // R2 unlock
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'h90, 2'd1, 6'b000001},  // R6
    {3'b100, 19'h00000, 8'hF0, 2'd0, 6'b000000},  // R8
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hA0, 2'd0, 6'b000000},
    {3'b100, 19'h12345, 8'h3C, 2'd2, 6'b100000},  // R3
    {3'b110, 19'h05555, 8'hAA, 2'd2, 6'b000000},  // R9
    {3'b110, 19'h00000, 8'hB0, 2'd2, 6'b000000},  // R10 no suspend in program
    {3'b001, 19'h00000, 8'h00, 2'd0, 6'b000000},  // R12
    {3'b100, 19'h7D555, 8'hAA, 2'd0, 6'b000000},  // R2 high bits ignored
    {3'b100, 19'h52AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'h80, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h6ABCD, 8'h30, 2'd2, 6'b010000},  // R4
    {3'b110, 19'h00000, 8'hB0, 2'd0, 6'b000100},  // R10
    {3'b100, 19'h00000, 8'h30, 2'd2, 6'b000010},  // R11
    {3'b001, 19'h00000, 8'h00, 2'd0, 6'b000000},  // R12
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAB, 8'h55, 2'd0, 6'b000000},  // R7 bad unlock address
    {3'b100, 19'h05555, 8'hA0, 2'd0, 6'b000000},  // R7 restart needed
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'h80, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h00000, 8'h10, 2'd2, 6'b001000},  // R5
    {3'b001, 19'h00000, 8'h00, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'h80, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hF0, 2'd0, 6'b000000},  // R8 mid-erase
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'h20, 2'd0, 6'b000000},  // R7 unknown command
    {3'b100, 19'h05555, 8'hAA, 2'd0, 6'b000000},
    {3'b100, 19'h02AAA, 8'h55, 2'd0, 6'b000000},
    {3'b100, 19'h05555, 8'hA0, 2'd0, 6'b000000},
    {3'b100, 19'h00007, 8'hF0, 2'd2, 6'b100000},  // R3 F0 as data
    {3'b001, 19'h00000, 8'h00, 2'd0, 6'b000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(19'h05555, 8'hAA);
    bus_wr(19'h02AAA, 8'h55);
  endtask

  task automatic finish_op();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset pulses", {26'd0, pgm, blk, chip, sus, res, sig}, 32'd0);
    chk("R1 reset mode", {30'd0, mode}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {wr, busy, done, addr, data} = VEC[i][37:8];
      @(negedge clk);
      chk($sformatf("R13 vec%0d pulses", i), {26'd0, pgm, blk, chip, sus, res, sig},
          {26'd0, VEC[i][5:0]});
      chk($sformatf("R12 vec%0d mode", i), {30'd0, mode}, {30'd0, VEC[i][7:6]});
    end
    wr = 1'b0; busy = 1'b0; done = 1'b0;
    @(negedge clk);
    chk("R13 pulse ends", {26'd0, pgm, blk, chip, sus, res, sig}, 32'd0);

    // R3 target address and data
    unlock();
    bus_wr(19'h05555, 8'hA0);
    bus_wr(19'h41234, 8'h5A);
    chk("R3 pgm pulse", {31'd0, pgm}, 32'd1);
    chk("R3 pgm addr", {13'd0, paddr}, 32'h41234);
    chk("R3 pgm data", {24'd0, pdata}, 32'h5A);
    finish_op();

    // R4 block select
    unlock();
    bus_wr(19'h05555, 8'h80);
    unlock();
    bus_wr(19'h30000, 8'h30);
    chk("R4 blk pulse", {31'd0, blk}, 32'd1);
    chk("R4 blk sel", {29'd0, bsel}, 32'd3);
    finish_op();

    // R1 reset mid-sequence forgets the unlock pair
    unlock();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_wr(19'h05555, 8'hA0);
    bus_wr(19'h01111, 8'h77);
    chk("R1 no pgm after reset", {31'd0, pgm}, 32'd0);
    chk("R1 mode after reset", {30'd0, mode}, 32'd0);

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule